// File: doc/BRIEF.md
# Key-Armed Machine-Cycle Watchdog

This block is a software-supervision watchdog for a small controller core. It stays dormant after a hardware reset and becomes active only when software writes a fixed two-byte key, first `1Eh` and then `E1h`, to a write-only service register. Software then repeats the same key pair at regular intervals to restart the count. The counter is 13 bits wide and advances on each machine-cycle enable. If it counts past its all-ones value, the block raises a one-clock internal reset request. It also drives an active-high external reset pulse that lasts a fixed number of oscillator clocks, unless the reset-output disable bit is set.

The counter cannot be read or loaded. Once the watchdog is armed, no write can disarm it; only a hardware reset or its own overflow does that. The count freezes in power-down, because the oscillator stops there. In idle the count continues by default, and stops when the halt-in-idle control bit is set. After power-down ends with the wake-up interrupt pin still low, counting stays frozen until that pin returns high.

Top module: `wdog_key_timer`

## Requirements
- R1: After hardware reset both outputs are low and the watchdog is disarmed. It never raises a reset request until the key is written, however long it runs.
- R2: Two consecutive register writes of `1Eh` and then `E1h` arm the watchdog with a count of zero. The count advances by one on each clock where `cyc_en` is high and no hold condition applies. `rst_req` is high in the cycle after the 8192nd counted clock that follows the clock in which `E1h` is written.
- R3: Writing the same ordered key pair while the watchdog is armed returns the count to zero, so the next overflow comes 8192 counted clocks after that `E1h` write.
- R4: An overflow raises `rst_req` for exactly one clock and disarms the watchdog. No further request comes until the key is written again.
- R5: On overflow, `rst_pulse` goes high in the same cycle as `rst_req` and stays high for exactly 98 clocks. If `rst_out_dis` is 1 at the overflow clock, `rst_pulse` stays low.
- R6: A key write only counts when `E1h` directly follows `1Eh`. Any other byte after `1Eh` abandons the sequence. A `1Eh` write always starts a new sequence. A lone `E1h` has no effect.
- R7: While `idle_mode` is high, the count keeps advancing if `halt_in_idle` is 0 and freezes if it is 1. It resumes when idle ends.
- R8: While `pd_mode` is high the count does not change.
- R9: If `wake_pin` is low when power-down ends, the count stays frozen until `wake_pin` is seen high.
- R10: Once the watchdog is armed, writes of other bytes and broken key sequences neither disarm it nor change its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Byte written to the service register |
| cyc_en | input | 1 | One-clock strobe per machine cycle |
| idle_mode | input | 1 | Core is in idle |
| pd_mode | input | 1 | Core is in power-down (oscillator stopped) |
| halt_in_idle | input | 1 | 1 freezes the count during idle |
| rst_out_dis | input | 1 | 1 suppresses the external reset pulse |
| wake_pin | input | 1 | Level of the wake-up interrupt pin |
| rst_pulse | output | 1 | External reset pulse, active high |
| rst_req | output | 1 | One-clock internal reset request |

## Verification
Every write is sampled on the rising edge that follows its negative-edge setup. The bench counts falling edges from the return of the `E1h` write, so an unstalled overflow shows `rst_req` at exactly the 8192nd falling edge. A frozen interval of N clocks adds N to that figure, and the checks compare against 8192 taken from the end of the freeze. The external pulse is sampled high at that same falling edge and then counted over 98 further samples. `rst_req` is checked low one sample after its rise. Checks that expect silence watch both outputs across more than a full count period.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   typedef enum logic [0:0] {
      KS_WAIT_FIRST  = 1'b0,
      KS_WAIT_SECOND = 1'b1
   } key_state_t;

   typedef struct packed {
      logic pd;
      logic idle;
      logic halt_idle;
      logic wake;
   } sleep_ctl_t;
endpackage

// File: rtl/wdk_key_seq.sv
module wdk_key_seq
   import wdk_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter logic [7:0]  KEY_FIRST  = 8'h1E,
   parameter logic [7:0]  KEY_SECOND = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              key_ok
);
   localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

   key_state_t state_q;

   assign key_ok = wr_en && (state_q == KS_WAIT_SECOND) && (wr_data == K2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KS_WAIT_FIRST;
      end else if (clr) begin
         state_q <= KS_WAIT_FIRST;
      end else if (wr_en) begin
         state_q <= (wr_data == K1) ? KS_WAIT_SECOND : KS_WAIT_FIRST;
      end
   end
endmodule

// File: rtl/wdk_stall.sv
module wdk_stall
   import wdk_pkg::*;
#(
   parameter bit WAKE_GATE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_en,
   input  sleep_ctl_t slp,
   output logic       tick
);
   logic wake_block;

   generate
      if (WAKE_GATE) begin : g_wake_gate
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= 1'b0;
            end else begin
               hold_q <= slp.pd | (hold_q & ~slp.wake);
            end
         end
         assign wake_block = hold_q & ~slp.wake;
      end else begin : g_no_wake_gate
         assign wake_block = 1'b0;
      end
   endgenerate

   assign tick = cyc_en & ~slp.pd & ~(slp.idle & slp.halt_idle) & ~wake_block;
endmodule

// File: rtl/wdk_cycle_ctr.sv
module wdk_cycle_ctr #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_ok,
   input  logic             tick,
   output logic             armed,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assign ovf = armed && tick && (count == CNT_MAX) && !key_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         count <= '0;
      end else if (key_ok) begin
         armed <= 1'b1;
         count <= '0;
      end else if (ovf) begin
         armed <= 1'b0;
         count <= '0;
      end else if (armed && tick) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
   parameter int PULSE_LEN = 98
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic out_dis,
   output logic rst_pulse,
   output logic rst_req
);
   localparam int PW = $clog2(PULSE_LEN + 1);
   localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fire;
         if (fire && !out_dis) begin
            left_q <= LEN;
         end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign rst_pulse = (left_q != '0);
endmodule

// File: rtl/wdog_key_timer.sv
module wdog_key_timer
   import wdk_pkg::*;
#(
   parameter int         CNT_W      = 13,
   parameter int         PULSE_LEN  = 98,
   parameter logic [7:0] KEY_FIRST  = 8'h1E,
   parameter logic [7:0] KEY_SECOND = 8'hE1,
   parameter bit         WAKE_GATE  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       cyc_en,
   input  logic       idle_mode,
   input  logic       pd_mode,
   input  logic       halt_in_idle,
   input  logic       rst_out_dis,
   input  logic       wake_pin,
   output logic       rst_pulse,
   output logic       rst_req
);
   localparam longint PERIOD = longint'(1) << CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("wdog_key_timer: CNT_W out of range");
      end
      if (PULSE_LEN < 1 || longint'(PULSE_LEN) >= PERIOD) begin : g_bad_pulse
         $error("wdog_key_timer: PULSE_LEN must be 1 .. 2**CNT_W-1");
      end
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
         $error("wdog_key_timer: key bytes must differ");
      end
   endgenerate

   logic             key_ok_w;
   logic             tick_w;
   logic             armed_w;
   logic             ovf_w;
   logic [CNT_W-1:0] count_w;
   sleep_ctl_t       slp_w;

   assign slp_w = '{pd: pd_mode, idle: idle_mode, halt_idle: halt_in_idle, wake: wake_pin};

   wdk_key_seq #(
      .DATA_W    (8),
      .KEY_FIRST (KEY_FIRST),
      .KEY_SECOND(KEY_SECOND)
   ) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ovf_w),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .key_ok (key_ok_w)
   );

   wdk_stall #(
      .WAKE_GATE(WAKE_GATE)
   ) u_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc_en(cyc_en),
      .slp   (slp_w),
      .tick  (tick_w)
   );

   wdk_cycle_ctr #(
      .CNT_W(CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .key_ok(key_ok_w),
      .tick  (tick_w),
      .armed (armed_w),
      .count (count_w),
      .ovf   (ovf_w)
   );

   wdk_pulse #(
      .PULSE_LEN(PULSE_LEN)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (ovf_w),
      .out_dis  (rst_out_dis),
      .rst_pulse(rst_pulse),
      .rst_req  (rst_req)
   );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
   parameter int CNT_W     = 13,
   parameter int PULSE_LEN = 98
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             idle_mode,
   input logic             pd_mode,
   input logic             halt_in_idle,
   input logic             rst_out_dis,
   input logic             rst_pulse,
   input logic             rst_req,
   input logic             armed,
   input logic [CNT_W-1:0] count
);
   localparam int HW = $clog2(PULSE_LEN + 2);
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (rst_pulse) begin
         hi_cnt <= hi_cnt + 1'b1;
      end else begin
         hi_cnt <= '0;
      end
   end

   AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !rst_req); // R1
   AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R4
   AST_REQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req && !$past(wr_en) |-> !armed); // R4
   AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req && !$past(rst_out_dis) |-> rst_pulse); // R5
   AST_PULSE_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req && $past(rst_out_dis) |-> !rst_pulse); // R5
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pulse) |-> hi_cnt == HW'(PULSE_LEN)); // R5
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_mode && halt_in_idle && !wr_en |=> $stable(count)); // R7
   AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      pd_mode && !wr_en |=> $stable(count)); // R8
endmodule

bind wdog_key_timer wdk_checker #(
   .CNT_W    (CNT_W),
   .PULSE_LEN(PULSE_LEN)
) u_wdk_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .idle_mode   (idle_mode),
   .pd_mode     (pd_mode),
   .halt_in_idle(halt_in_idle),
   .rst_out_dis (rst_out_dis),
   .rst_pulse   (rst_pulse),
   .rst_req     (rst_req),
   .armed       (armed_w),
   .count       (count_w)
);

// File: tb/test_wdog_key_timer.sv
`timescale 1ns/1ps
module test_wdog_key_timer;
   localparam int FULL = 8192;
   localparam int PLEN = 98;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       cyc_en = 1'b1;
   logic       idle_mode = 1'b0;
   logic       pd_mode = 1'b0;
   logic       halt_in_idle = 1'b0;
   logic       rst_out_dis = 1'b0;
   logic       wake_pin = 1'b1;
   logic       rst_pulse;
   logic       rst_req;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   wdog_key_timer i_wdog_key_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cyc_en(cyc_en), .idle_mode(idle_mode), .pd_mode(pd_mode),
      .halt_in_idle(halt_in_idle), .rst_out_dis(rst_out_dis),
      .wake_pin(wake_pin), .rst_pulse(rst_pulse), .rst_req(rst_req)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      wr_en = 1'b0; cyc_en = 1'b1; idle_mode = 1'b0; pd_mode = 1'b0;
      halt_in_idle = 1'b0; rst_out_dis = 1'b0; wake_pin = 1'b1;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic arm();
      wr(8'h1E);
      wr(8'hE1);
   endtask

   task automatic wait_req(output int n, input int lim);
      n = lim;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (rst_req) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic quiet(input int cycles, output int hits);
      hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (rst_req || rst_pulse) hits++;
      end
   endtask

   task automatic t_reset_state();
      int h;
      do_reset();
      chk(rst_pulse == 1'b0, "R1 pulse after reset", int'(rst_pulse), 0);
      chk(rst_req == 1'b0, "R1 req after reset", int'(rst_req), 0);
      wr(8'hE1);
      quiet(FULL + 800, h);
      chk(h == 0, "R1/R6 unarmed stays silent", h, 0);
   endtask

   task automatic t_expire();
      int n, w, h;
      do_reset();
      arm();
      wait_req(n, FULL + 50);
      chk(n == FULL, "R2 overflow time", n, FULL);
      chk(rst_pulse == 1'b1, "R5 pulse with request", int'(rst_pulse), 1);
      w = 1;
      @(negedge clk);
      chk(rst_req == 1'b0, "R4 request one clock", int'(rst_req), 0);
      while (rst_pulse && w < 500) begin
         w++;
         @(negedge clk);
      end
      chk(w == PLEN, "R5 pulse width", w, PLEN);
      quiet(FULL + 800, h);
      chk(h == 0, "R4 disarmed after overflow", h, 0);
   endtask

   task automatic t_service();
      int n, h;
      do_reset();
      arm();
      quiet(5000, h);
      chk(h == 0, "R3 no reset before service", h, 0);
      arm();
      wait_req(n, FULL + 50);
      chk(n == FULL, "R3 service restarts count", n, FULL);
   endtask

   task automatic t_abort();
      int n, h;
      do_reset();
      wr(8'h1E); wr(8'h55); wr(8'hE1);
      quiet(FULL + 800, h);
      chk(h == 0, "R6 broken key ignored", h, 0);
      wr(8'h1E); wr(8'h1E); wr(8'hE1);
      wait_req(n, FULL + 50);
      chk(n == FULL, "R6 repeated first byte restarts", n, FULL);
   endtask

   task automatic t_armed_abort();
      int n, h;
      do_reset();
      arm();
      quiet(4000, h);
      wr(8'h1E); wr(8'h00); wr(8'hE1); wr(8'h3C);
      wait_req(n, FULL + 50);
      chk(n == FULL - 4004, "R10 bad writes keep count", n, FULL - 4004);
   endtask

   task automatic t_out_dis();
      int n, h;
      do_reset();
      rst_out_dis = 1'b1;
      arm();
      wait_req(n, FULL + 50);
      chk(n == FULL, "R5 request with output disabled", n, FULL);
      chk(rst_pulse == 1'b0, "R5 pulse suppressed", int'(rst_pulse), 0);
      h = 0;
      for (int i = 0; i < PLEN + 10; i++) begin
         @(negedge clk);
         if (rst_pulse) h++;
      end
      chk(h == 0, "R5 pulse stays low", h, 0);
   endtask

   task automatic t_idle();
      int n;
      do_reset();
      arm();
      idle_mode = 1'b1; halt_in_idle = 1'b1;
      repeat (1000) @(negedge clk);
      idle_mode = 1'b0;
      wait_req(n, FULL + 50);
      chk(n == FULL, "R7 halt in idle freezes", n, FULL);
      do_reset();
      arm();
      idle_mode = 1'b1; halt_in_idle = 1'b0;
      repeat (1000) @(negedge clk);
      idle_mode = 1'b0;
      wait_req(n, FULL + 50);
      chk(n == FULL - 1000, "R7 idle keeps counting", n, FULL - 1000);
   endtask

   task automatic t_power_down();
      int n;
      do_reset();
      arm();
      pd_mode = 1'b1; wake_pin = 1'b0;
      repeat (500) @(negedge clk);
      pd_mode = 1'b0;
      repeat (300) @(negedge clk);
      wake_pin = 1'b1;
      wait_req(n, FULL + 50);
      chk(n == FULL, "R9 held until wake pin high", n, FULL);
      do_reset();
      arm();
      pd_mode = 1'b1;
      repeat (500) @(negedge clk);
      pd_mode = 1'b0;
      wait_req(n, FULL + 50);
      chk(n == FULL, "R8 power-down freezes", n, FULL);
   endtask

   task automatic t_half_rate();
      int n;
      do_reset();
      arm();
      n = 0;
      cyc_en = 1'b1;
      for (int i = 1; i <= 2 * FULL + 10; i++) begin
         @(negedge clk);
         cyc_en = ~cyc_en;
         if (rst_req) begin
            n = i;
            break;
         end
      end
      cyc_en = 1'b1;
      chk(n == 2 * FULL - 1, "R2 counts only enabled cycles", n, 2 * FULL - 1);
   endtask

   initial begin
      fork
         begin
            t_reset_state();
            t_expire();
            t_service();
            t_abort();
            t_armed_abort();
            t_out_dis();
            t_idle();
            t_power_down();
            t_half_rate();
         end
         begin
            repeat (195000) @(posedge clk);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule